// File: doc/BRIEF.md
# Gated Tick Counter with Byte-Buffered Access

This block is a 16-bit up-counter on an 8-bit register bus. It advances on single-cycle tick pulses from whichever count source the surrounding logic selects. A 2-bit field sets a prescaler that divides those ticks by 1, 2, 4 or 8. An optional gate can hold the count. The gate input is first passed through a two-flop synchronizer, and a polarity bit chooses which gate level lets the counter run.

Software reaches the count through two byte addresses. In 16-bit mode, a high-byte shadow register makes a two-access read or write behave as a single 16-bit operation. Reading the low byte captures the live high byte into the shadow. A write to the high byte only fills the shadow, and the following low-byte write loads both bytes at once. A third address holds the control bits and the sticky wrap flag.

Top module: `gtc_top`

## Requirements
- R1: Reset clears the counter, the high-byte shadow, the prescaler, every control bit and the wrap flag, so all three addresses read 0x00.
- R2: With run set (control bit 0) and gate enable clear (control bit 4), each tick_in pulse sampled at a clock edge advances the counter (divide-by-1) whatever the gate level.
- R3: The divide field (control bits 3:2, code k) makes the counter advance once every 2^k qualified ticks.
- R4: In 16-bit mode (control bit 1), a read strobe on the low address (0) copies the live high byte into the shadow at that edge, and the high address (1) then reads the shadow and not the live byte.
- R5: In 16-bit mode, a write to the high address changes only the shadow, and a write to the low address loads the counter with {shadow, written byte} in one edge.
- R6: With 16-bit mode clear, the high address reads and writes the live high byte directly, and a low-address read leaves the shadow unchanged.
- R7: A write to the low address restarts the prescaler from zero. A write to the high address leaves the prescaler phase untouched.
- R8: With gate enable set, polarity (control bit 5) 0 counts while the synchronized gate is low and holds while it is high. Polarity 1 counts while it is high and holds while it is low.
- R9: A change on gate_in first affects counting at the second clock edge after it is sampled.
- R10: Advancing from 0xFFFF to 0x0000 sets a sticky wrap flag, seen at control-address bit 7 and on ovf_flag. A control write with bit 7 set clears it, and a wrap in the same cycle wins over the clear.
- R11: A bus write that changes the counter in the same cycle as an advance takes effect and the advance is dropped.
- R12: With run clear, ticks leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 control, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect only: shadow capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| tick_in | input | 1 | Synchronous one-cycle count pulse |
| gate_in | input | 1 | Asynchronous gate level |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
Bus writes, read strobes and ticks are applied in the half cycle before an edge, and each takes effect at that one edge. bus_rdata is combinational, so the bench reads the new state at the following falling edge, with no strobe set, at all three addresses. A gate change reaches counting only after two synchronizer flops. The bench model therefore keeps its own two-stage gate history and compares the counter at every falling edge, both in directed gate scenarios where ticks coincide with the change and in a long random run.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // control register layout, bit 0 = run
    typedef struct packed {
        logic       gate_pol;
        logic       gate_en;
        logic [1:0] div;
        logic       wide;
        logic       run;
    } ctl_t;

    localparam int CTL_W   = $bits(ctl_t);
    localparam int OVF_BIT = 7;
endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign d_out = sh_q[STAGES-1];
endmodule

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             adv
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = ~({PRE_W{1'b1}} << div);
        cnt_d = cnt_q;
        adv   = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            if (cnt_q >= limit) begin
                cnt_d = '0;
                adv   = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gtc_top.sv
module gtc_top #(
    parameter int BYTE_W      = 8,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_in,
    input  logic              gate_in,
    output logic              ovf_flag
);
    import gtc_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  ctr;
        logic [BYTE_W-1:0] hbuf;
        ctl_t              ctl;
        logic              ovf;
    } state_t;

    state_t s_d, s_q;

    logic gate_s, gate_ok, step, adv;
    logic wr_lo, wr_hi, wr_ctl, rd_lo;
    logic [CNT_W-1:0]  ctr_now;
    logic [BYTE_W-1:0] hbuf_now;
    logic [CTL_W-1:0]  ctl_now;

    gtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (gate_in),
        .d_out (gate_s)
    );

    gtc_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .clear (wr_lo),
        .div   (s_q.ctl.div),
        .adv   (adv)
    );

    always_comb begin
        wr_lo   = bus_wr && (bus_addr == REG_LO);
        wr_hi   = bus_wr && (bus_addr == REG_HI);
        wr_ctl  = bus_wr && (bus_addr == REG_CTL);
        rd_lo   = bus_rd && (bus_addr == REG_LO);
        gate_ok = !s_q.ctl.gate_en || (gate_s == s_q.ctl.gate_pol);
        step    = s_q.ctl.run && tick_in && gate_ok;
    end

    always_comb begin
        s_d = s_q;

        if (wr_ctl) begin
            s_d.ctl = ctl_t'(bus_wdata[CTL_W-1:0]);
            if (bus_wdata[OVF_BIT]) s_d.ovf = 1'b0;
        end

        if (wr_lo) begin
            s_d.ctr = {(s_q.ctl.wide ? s_q.hbuf : s_q.ctr[CNT_W-1:BYTE_W]), bus_wdata};
        end else if (wr_hi && !s_q.ctl.wide) begin
            s_d.ctr[CNT_W-1:BYTE_W] = bus_wdata;
        end else if (adv) begin
            s_d.ctr = s_q.ctr + 1'b1;
            if (&s_q.ctr) s_d.ovf = 1'b1;
        end

        if (wr_hi && s_q.ctl.wide) begin
            s_d.hbuf = bus_wdata;
        end else if (rd_lo && s_q.ctl.wide) begin
            s_d.hbuf = s_q.ctr[CNT_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (bus_addr)
            REG_LO:  bus_rdata = s_q.ctr[BYTE_W-1:0];
            REG_HI:  bus_rdata = s_q.ctl.wide ? s_q.hbuf : s_q.ctr[CNT_W-1:BYTE_W];
            REG_CTL: bus_rdata = {s_q.ovf, {(BYTE_W-CTL_W-1){1'b0}}, s_q.ctl};
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_flag = s_q.ovf;
    assign ctr_now  = s_q.ctr;
    assign hbuf_now = s_q.hbuf;
    assign ctl_now  = s_q.ctl;
endmodule

// File: rtl/gtc_checker.sv
module gtc_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic                tick_in,
    input logic                ovf_flag,
    input logic                gate_s,
    input logic [2*BYTE_W-1:0] ctr_now,
    input logic [BYTE_W-1:0]   hbuf_now,
    input logic [5:0]          ctl_now
);
    localparam int CNT_W = 2 * BYTE_W;

    logic run, wide, g_en, g_pol;
    assign run   = ctl_now[0];
    assign wide  = ctl_now[1];
    assign g_en  = ctl_now[4];
    assign g_pol = ctl_now[5];

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(ctr_now)); // R12

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && g_en && (gate_s != g_pol) && !bus_wr) |=> $stable(ctr_now)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(bus_wr && bus_addr == 2'd2 && bus_wdata[7])) |=> ovf_flag); // R10

    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && wide && !bus_wr)
        |=> hbuf_now == $past(ctr_now[CNT_W-1:BYTE_W])); // R4

    AST_HI_TO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && wide && !tick_in) |=> $stable(ctr_now)); // R5

    AST_LOW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0)
        |=> ctr_now[BYTE_W-1:0] == $past(bus_wdata)); // R11
endmodule

bind gtc_top gtc_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .tick_in   (tick_in),
    .ovf_flag  (ovf_flag),
    .gate_s    (gate_s),
    .ctr_now   (ctr_now),
    .hbuf_now  (hbuf_now),
    .ctl_now   (ctl_now)
);

// File: tb/gtc_top_bench.sv
`timescale 1ns/100ps
module gtc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_in = 1'b0, gate_in = 1'b0;
    logic       ovf_flag;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // reference state
    logic [15:0] m_ctr = 16'h0;
    logic [7:0]  m_buf = 8'h0;
    logic [5:0]  m_ctl = 6'h0;
    logic        m_ovf = 1'b0;
    logic [2:0]  m_pre = 3'h0;
    logic        m_g1 = 1'b0, m_g2 = 1'b0;

    always #2.5 clk = ~clk;

    gtc_top u_gtc_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_in(tick_in), .gate_in(gate_in), .ovf_flag(ovf_flag)
    );

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_ctr[7:0];
            2'd1:    return m_ctl[1] ? m_buf : m_ctr[15:8];
            2'd2:    return {m_ovf, 1'b0, m_ctl};
            default: return 8'h00;
        endcase
    endfunction

    // advance the reference by one edge using the inputs held now
    task automatic model_step();
        logic       gate_ok, step, adv, wlo, whi, wct, rlo;
        logic [2:0] lim;
        wlo = bus_wr && bus_addr == 2'd0;
        whi = bus_wr && bus_addr == 2'd1;
        wct = bus_wr && bus_addr == 2'd2;
        rlo = bus_rd && bus_addr == 2'd0;
        gate_ok = !m_ctl[4] || (m_g2 == m_ctl[5]);
        step = m_ctl[0] && tick_in && gate_ok;
        lim = 3'((1 << m_ctl[3:2]) - 1);
        adv = 1'b0;
        if (wlo) m_pre = 3'd0;
        else if (step) begin
            if (m_pre >= lim) begin m_pre = 3'd0; adv = 1'b1; end
            else m_pre = m_pre + 3'd1;
        end
        if (wct && bus_wdata[7]) m_ovf = 1'b0;
        if (wlo) m_ctr = {(m_ctl[1] ? m_buf : m_ctr[15:8]), bus_wdata};
        else if (whi && !m_ctl[1]) m_ctr[15:8] = bus_wdata;
        else if (adv) begin
            if (m_ctr == 16'hFFFF) m_ovf = 1'b1;
            m_ctr = m_ctr + 16'd1;
        end
        if (whi && m_ctl[1]) m_buf = bus_wdata;
        else if (rlo && m_ctl[1]) m_buf = m_ctr[15:8];
        if (wct) m_ctl = bus_wdata[5:0];
        m_g2 = m_g1;
        m_g1 = gate_in;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // combinational readback of all three addresses, no strobe
    task automatic peek(input string req);
        for (int a = 0; a < 3; a++) begin
            bus_addr = 2'(a);
            #0.2;
            check(req, bus_rdata, exp_rd(2'(a)), $sformatf("addr%0d", a));
        end
        checks++;
        if (ovf_flag !== m_ovf) begin
            failures++;
            $display("FAIL %s ovf_flag actual=%0b expected=%0b", req, ovf_flag, m_ovf);
        end
    endtask

    // one clock: drive, edge, update reference, release at the falling edge
    task automatic cyc(input logic [1:0] a, input bit wr, input bit rd, input logic [7:0] d, input bit tk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d; tick_in = tk;
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; tick_in = 1'b0;
    endtask

    task automatic wctl(input logic [7:0] v); cyc(2'd2, 1, 0, v, 0); endtask
    task automatic wlo(input logic [7:0] v);  cyc(2'd0, 1, 0, v, 0); endtask
    task automatic whi(input logic [7:0] v);  cyc(2'd1, 1, 0, v, 0); endtask
    task automatic rlo();                     cyc(2'd0, 0, 1, 8'h00, 0); endtask
    task automatic ticks(input int n); for (int i = 0; i < n; i++) cyc(2'd3, 0, 0, 8'h00, 1); endtask
    task automatic idle(input int n);  for (int i = 0; i < n; i++) cyc(2'd3, 0, 0, 8'h00, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: everything zero after reset
        peek("R1");
        check("R1", bus_rdata, 8'h00, "ctl literal");

        // R2: free run, gate ignored
        wctl(8'h01);
        gate_in = 1'b1; ticks(3); gate_in = 1'b0; ticks(2);
        peek("R2");
        bus_addr = 2'd0; #0.2; check("R2", bus_rdata, 8'h05, "five ticks");

        // R3: every divide setting
        for (int k = 0; k < 4; k++) begin
            wctl(8'(8'h01 | (k << 2)));
            wlo(8'h00);
            ticks(11);
            peek("R3");
        end

        // R10: wrap sets sticky flag, explicit clear
        wctl(8'h01); whi(8'hFF); wlo(8'hFE); ticks(3); idle(2);
        peek("R10");
        check("R10", {7'd0, ovf_flag}, 8'h01, "flag set");
        wctl(8'h81); peek("R10");
        whi(8'hFF); wlo(8'hFF);
        bus_addr = 2'd2; bus_wr = 1'b1; bus_wdata = 8'h81; tick_in = 1'b1;
        @(posedge clk); model_step(); @(negedge clk);
        bus_wr = 1'b0; tick_in = 1'b0;
        peek("R10"); // wrap beats clear

        // R4: snapshot across a rollover
        wctl(8'h03); whi(8'h12); wlo(8'hFF); peek("R5");
        rlo(); ticks(1); peek("R4");
        check("R4", exp_rd(2'd1), 8'h12, "shadow model sanity");

        // R5: high write with tick goes to shadow only, then low write loads both
        cyc(2'd1, 1, 0, 8'hAB, 1); peek("R5");
        wlo(8'h10); peek("R5");

        // R6: narrow mode direct high access, low read leaves shadow
        wctl(8'h01); whi(8'h55); peek("R6");
        rlo(); wctl(8'h02); peek("R6");

        // R7: prescaler phase kept across a high write
        wctl(8'h0D); wlo(8'h00); ticks(5); whi(8'h00); ticks(3); peek("R7");
        wlo(8'h00); ticks(5); wlo(8'h00); ticks(3); peek("R7");

        // R8: polarity 0 then 1
        wctl(8'h11); wlo(8'h00);
        gate_in = 1'b1; idle(3); ticks(4); peek("R8");
        gate_in = 1'b0; idle(3); ticks(4); peek("R8");
        wctl(8'h31);
        ticks(3); peek("R8");
        gate_in = 1'b1; idle(3); ticks(3); peek("R8");

        // R9: two-edge synchronizer delay
        gate_in = 1'b0; idle(3); wlo(8'h00);
        gate_in = 1'b1; ticks(1); peek("R9"); ticks(1); peek("R9"); ticks(1); peek("R9");

        // R11: writes beat a coinciding advance
        wctl(8'h01); wlo(8'h20);
        cyc(2'd1, 1, 0, 8'h44, 1); peek("R11");
        cyc(2'd0, 1, 0, 8'h77, 1); peek("R11");

        // R12: stopped
        wctl(8'h00); ticks(4); peek("R12");

        // random mix, compared against the reference every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] a;
            logic [7:0] d;
            int op;
            op = int'($urandom_range(0, 99));
            a  = 2'($urandom_range(0, 2));
            d  = 8'($urandom);
            if (a == 2'd2 && $urandom_range(0, 4) != 0) d[0] = 1'b1;
            if ($urandom_range(0, 9) == 0) gate_in = ~gate_in;
            if (op < 65)      cyc(2'd3, 0, 0, 8'h00, 1'($urandom));
            else if (op < 85) cyc(a, 0, 1, 8'h00, 1'($urandom));
            else              cyc(a, 1, 0, d, 1'($urandom));
            peek("R2");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule